// File: doc/BRIEF.md
# Gated Mixture-of-Experts Output Combiner

This block sits at the end of a modular classifier made of several expert networks and one gating network. Every expert scores the same input vector over four disturbance classes. The encoding is 0 for voltage sag, 1 for voltage swell, 2 for harmonics and 3 for transient. The gating network gives one score per expert. An upstream master issues a broadcast request when it hands the input to the experts, and the gating scores are presented with that request. The experts then finish in any order. Each one raises its own valid strobe together with its class scores.

The combiner records each expert's first completion after a broadcast. It starts the combination only after every expert has reported. The gating scores are turned into softmax weights. The largest gating score is subtracted first, so the exponential argument is never positive and the exponential is read from a table computed at elaboration. The combiner sums each expert's class scores scaled by its weight, normalises the result with one reciprocal of the weight total, and picks the winning class. It then raises a one-cycle done pulse and is ready for the next broadcast. All values are signed Q4.12.

Top module: `moe_combiner`

## Requirements
- R1: During and after reset, `bcast_ready` is 1, `mix_done` is 0, `mix_class` is 0 and every `mix_score` field is 0.
- R2: A broadcast is taken when `bcast_valid` and `bcast_ready` are both 1 at a clock edge. `bcast_ready` is 0 from the next cycle until the cycle of the done pulse, and a `bcast_valid` seen while it is 0 has no effect on the result.
- R3: The gating scores are sampled from `gate_score` (expert j at bits [16j+15:16j]) at the edge that takes the broadcast. Later changes on that bus do not alter the result.
- R4: Expert j's four scores (class k at bits [16(4j+k)+15:16(4j+k)]) are captured at its first `exp_valid[j]` after a broadcast. Further strobes from that expert before the done pulse are ignored.
- R5: `mix_done` is 1 for exactly one cycle, in the second cycle after the edge at which the last missing expert strobe was sampled.
- R6: Each expert's weight is round(4096 * exp(-k/8)), where k = min(63, floor((max_gate - gate_j) / 512)) in raw Q4.12 units.
- R7: Combined score k equals (sum_j w_j * s_jk) * floor(2^24 / sum_j w_j), shifted right arithmetically by 24 (rounded toward minus infinity).
- R8: `mix_class` is the index of the largest combined score. On a tie, the lowest index wins.
- R9: `mix_score` and `mix_class` change only in the cycle of a done pulse and hold their values otherwise.
- R10: Expert strobes that arrive while no broadcast is pending are ignored. They neither capture data nor count toward completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcast_valid | input | 1 | Broadcast request: input vector sent to the experts |
| bcast_ready | output | 1 | Combiner idle, broadcast can be taken |
| gate_score | input | N_EXP*DW | Gating network outputs, one Q4.12 field per expert |
| exp_valid | input | N_EXP | Per-expert completion strobe |
| exp_score | input | N_EXP*N_CLS*DW | Expert class scores, Q4.12, expert-major |
| mix_score | output | N_CLS*DW | Combined class scores, Q4.12 |
| mix_class | output | $clog2(N_CLS) | Winning class index |
| mix_done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its defaults: three experts, four classes, Q4.12 values and a 64-entry exponential table spaced one eighth apart. With these values, gating spreads wider than 8.0 reach the saturated last table entry, and expert scores at the full 16-bit extremes show that the accumulator and the reciprocal product are wide enough. Completion orders are rotated and spaced with varying gaps. Stray strobes and requests are sent while idle, while busy and after an expert has already reported.

// File: rtl/moe_pkg.sv
package moe_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_CALC = 2'd2
   } mix_state_t;

   // Weight table entry: e^(-k * 2^shift / 2^frac) scaled to 2^frac, rounded.
   function automatic int exp_entry(input int k, input int frac, input int shift);
      real step;
      real val;
      step = real'(1 << shift) / real'(1 << frac);
      val  = $exp(-real'(k) * step) * real'(1 << frac);
      return $rtoi(val + 0.5);
   endfunction

endpackage

// File: rtl/moe_weights.sv
module moe_weights #(
   parameter int N_EXP      = 3,
   parameter int DW         = 16,
   parameter int FRAC       = 12,
   parameter int LUT_BITS   = 6,
   parameter int STEP_SHIFT = 9
) (
   input  logic signed [DW-1:0] gate  [N_EXP],
   output logic [FRAC:0]        wgt   [N_EXP],
   output logic [FRAC:0]        recip
);
   localparam int EW    = FRAC + 1;
   localparam int SW    = EW + $clog2(N_EXP);
   localparam int LUT_N = 1 << LUT_BITS;
   localparam int HW    = DW + 1 - STEP_SHIFT;
   localparam int QW    = 2 * FRAC + 1;
   localparam logic [QW-1:0] ONE_SQ = QW'(1) << (2 * FRAC);

   logic [EW-1:0]        lut [LUT_N];
   logic signed [DW-1:0] top_g;
   logic [SW-1:0]        total;

   for (genvar k = 0; k < LUT_N; k++) begin : g_lut
      localparam int ENTRY = moe_pkg::exp_entry(k, FRAC, STEP_SHIFT);
      assign lut[k] = EW'(ENTRY);
   end

   always_comb begin
      top_g = gate[0];
      for (int i = 1; i < N_EXP; i++)
         if (gate[i] > top_g) top_g = gate[i];
   end

   for (genvar i = 0; i < N_EXP; i++) begin : g_exp
      logic [DW:0]       gap;
      logic [HW-1:0]     coarse;
      logic [LUT_BITS-1:0] sel;
      assign gap    = {top_g[DW-1], top_g} - {gate[i][DW-1], gate[i]};
      assign coarse = gap[DW:STEP_SHIFT];
      assign sel    = (coarse > HW'(LUT_N - 1)) ? LUT_BITS'(LUT_N - 1)
                                                 : coarse[LUT_BITS-1:0];
      assign wgt[i] = lut[sel];
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < N_EXP; i++) total = total + SW'(wgt[i]);
   end

   assign recip = EW'(ONE_SQ / QW'(total));

endmodule

// File: rtl/moe_mix.sv
module moe_mix #(
   parameter int N_EXP = 3,
   parameter int N_CLS = 4,
   parameter int DW    = 16,
   parameter int FRAC  = 12
) (
   input  logic [FRAC:0]        wgt   [N_EXP],
   input  logic [FRAC:0]        recip,
   input  logic signed [DW-1:0] score [N_EXP][N_CLS],
   output logic signed [DW-1:0] mixed [N_CLS]
);
   localparam int EW  = FRAC + 1;
   localparam int PW  = EW + 1 + DW;
   localparam int AW  = PW + $clog2(N_EXP);
   localparam int XW  = AW + EW + 1;

   always_comb begin
      for (int k = 0; k < N_CLS; k++) begin : l_cls
         logic signed [PW-1:0] term;
         logic signed [AW-1:0] acc;
         logic signed [XW-1:0] prod;
         logic signed [XW-1:0] scaled;
         acc = '0;
         for (int i = 0; i < N_EXP; i++) begin
            term = $signed({1'b0, wgt[i]}) * score[i][k];
            acc  = acc + AW'(term);
         end
         prod     = acc * $signed({1'b0, recip});
         scaled   = prod >>> (2 * FRAC);
         mixed[k] = DW'(scaled);
      end
   end

endmodule

// File: rtl/moe_argmax.sv
module moe_argmax #(
   parameter int N_CLS = 4,
   parameter int DW    = 16,
   localparam int CW   = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
   input  logic signed [DW-1:0] val [N_CLS],
   output logic [CW-1:0]        idx
);
   logic signed [DW-1:0] best;

   always_comb begin
      best = val[0];
      idx  = '0;
      for (int k = 1; k < N_CLS; k++) begin
         if (val[k] > best) begin
            best = val[k];
            idx  = CW'(k);
         end
      end
   end

endmodule

// File: rtl/moe_combiner.sv
module moe_combiner #(
   parameter int N_EXP      = 3,
   parameter int N_CLS      = 4,
   parameter int DW         = 16,
   parameter int FRAC       = 12,
   parameter int LUT_BITS   = 6,
   parameter int STEP_SHIFT = 9,
   localparam int CW        = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bcast_valid,
   output logic                      bcast_ready,
   input  logic [N_EXP*DW-1:0]       gate_score,
   input  logic [N_EXP-1:0]          exp_valid,
   input  logic [N_EXP*N_CLS*DW-1:0] exp_score,
   output logic [N_CLS*DW-1:0]       mix_score,
   output logic [CW-1:0]             mix_class,
   output logic                      mix_done
);
   import moe_pkg::*;

   localparam int EW = FRAC + 1;

   if (N_EXP < 2) begin : g_bad_exp
      $error("moe_combiner: N_EXP must be at least 2");
   end
   if (DW <= FRAC + 1) begin : g_bad_dw
      $error("moe_combiner: DW must leave integer bits above FRAC");
   end
   if (DW + 1 - STEP_SHIFT < LUT_BITS) begin : g_bad_lut
      $error("moe_combiner: table index wider than the gap field");
   end

   mix_state_t           st;
   logic [N_EXP-1:0]     seen;
   logic signed [DW-1:0] gate_q [N_EXP];
   logic signed [DW-1:0] sc_q   [N_EXP][N_CLS];
   logic [EW-1:0]        wgt_w  [N_EXP];
   logic [EW-1:0]        wgt_q  [N_EXP];
   logic [EW-1:0]        recip_w;
   logic [EW-1:0]        recip_q;
   logic signed [DW-1:0] mix_w  [N_CLS];
   logic [CW-1:0]        cls_w;

   assign bcast_ready = (st == ST_IDLE);

   moe_weights #(
      .N_EXP(N_EXP), .DW(DW), .FRAC(FRAC),
      .LUT_BITS(LUT_BITS), .STEP_SHIFT(STEP_SHIFT)
   ) i_weights (
      .gate(gate_q), .wgt(wgt_w), .recip(recip_w)
   );

   moe_mix #(
      .N_EXP(N_EXP), .N_CLS(N_CLS), .DW(DW), .FRAC(FRAC)
   ) i_mix (
      .wgt(wgt_q), .recip(recip_q), .score(sc_q), .mixed(mix_w)
   );

   moe_argmax #(
      .N_CLS(N_CLS), .DW(DW)
   ) i_argmax (
      .val(mix_w), .idx(cls_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         seen      <= '0;
         mix_done  <= 1'b0;
         mix_score <= '0;
         mix_class <= '0;
         recip_q   <= '0;
         for (int j = 0; j < N_EXP; j++) begin
            gate_q[j] <= '0;
            wgt_q[j]  <= '0;
            for (int k = 0; k < N_CLS; k++) sc_q[j][k] <= '0;
         end
      end else begin
         mix_done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (bcast_valid) begin
                  for (int j = 0; j < N_EXP; j++)
                     gate_q[j] <= gate_score[j*DW +: DW];
                  seen <= '0;
                  st   <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               for (int j = 0; j < N_EXP; j++) begin
                  if (exp_valid[j] && !seen[j]) begin
                     seen[j] <= 1'b1;
                     for (int k = 0; k < N_CLS; k++)
                        sc_q[j][k] <= exp_score[(j*N_CLS+k)*DW +: DW];
                  end
               end
               if (&seen) begin
                  wgt_q   <= wgt_w;
                  recip_q <= recip_w;
                  st      <= ST_CALC;
               end
            end
            ST_CALC: begin
               for (int k = 0; k < N_CLS; k++) mix_score[k*DW +: DW] <= mix_w[k];
               mix_class <= cls_w;
               mix_done  <= 1'b1;
               seen      <= '0;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

module moe_combiner_chk #(
   parameter int N_EXP = 3,
   parameter int N_CLS = 4,
   parameter int DW    = 16,
   localparam int CW   = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bcast_valid,
   input logic                 bcast_ready,
   input logic [N_EXP-1:0]     exp_valid,
   input logic [N_CLS*DW-1:0]  mix_score,
   input logic [CW-1:0]        mix_class,
   input logic                 mix_done
);
   logic                 busy_c;
   logic [N_EXP-1:0]     got_c;
   logic signed [DW-1:0] sc [N_CLS];
   logic signed [DW-1:0] win;

   for (genvar k = 0; k < N_CLS; k++) begin : g_unpack
      assign sc[k] = mix_score[k*DW +: DW];
   end
   assign win = sc[mix_class];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c <= 1'b0;
         got_c  <= '0;
      end else if (mix_done) begin
         busy_c <= bcast_valid;
         got_c  <= '0;
      end else begin
         if (bcast_valid && bcast_ready) busy_c <= 1'b1;
         if (busy_c) got_c <= got_c | exp_valid;
      end
   end

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mix_done |=> !mix_done);
   // R5
   done_after_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mix_done |-> &got_c);
   // R2
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_valid && bcast_ready && !mix_done) |=> !bcast_ready);
   // R8
   class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mix_done |-> (int'(mix_class) < N_CLS));
   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_done |-> ($stable(mix_score) && $stable(mix_class)));

   for (genvar k = 0; k < N_CLS; k++) begin : g_am
      // R8
      argmax_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mix_done |-> ((int'(mix_class) > k) ? (win > sc[k]) : (win >= sc[k])));
   end

endmodule

bind moe_combiner moe_combiner_chk #(.N_EXP(N_EXP), .N_CLS(N_CLS), .DW(DW)) i_chk (.*);

// File: tb/test_moe_combiner.sv
`timescale 1ns/1ps
module test_moe_combiner;
   localparam int NE = 3;
   localparam int NC = 4;
   localparam int DW = 16;
   localparam int NV = 6;

   localparam int VG [NV][NE] = '{
      '{0, 0, 0}, '{4096, 0, -4096}, '{-20000, -20000, 20000},
      '{1000, 1500, 1200}, '{0, -600, -1100}, '{-3000, 2000, 100}};
   localparam int VS [NV][NE*NC] = '{
      '{4096, -2048, 1000, 0,  0, 3000, -4096, 500,  100, 200, 300, 400},
      '{-1000, 2500, 300, -200,  4000, 4000, -100, 0,  -3000, 100, 200, 8000},
      '{1200, 1300, -50, 7,  900, -900, 20, 20,  -500, -400, -300, -200},
      '{-4000, -3000, -2000, -100,  -8000, -50, -60, -70,  -1, -2, -3, -4},
      '{32767, -32768, 0, 100,  -32768, 32767, 5, 5,  32767, 32767, -32768, 0},
      '{0, 0, 0, 4095,  2048, -2048, 10000, -10000,  1, 2, 3, 4}};

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   bcast_valid = 1'b0;
   logic                   bcast_ready;
   logic [NE*DW-1:0]       gate_score = '0;
   logic [NE-1:0]          exp_valid = '0;
   logic [NE*NC*DW-1:0]    exp_score = '0;
   logic [NC*DW-1:0]       mix_score;
   logic [1:0]             mix_class;
   logic                   mix_done;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   moe_combiner #(.N_EXP(NE), .N_CLS(NC), .DW(DW)) i_moe_combiner (
      .clk(clk), .rst_n(rst_n), .bcast_valid(bcast_valid), .bcast_ready(bcast_ready),
      .gate_score(gate_score), .exp_valid(exp_valid), .exp_score(exp_score),
      .mix_score(mix_score), .mix_class(mix_class), .mix_done(mix_done));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int m_exp(input int gap);
      int k;
      k = gap / 512;
      if (k > 63) k = 63;
      return $rtoi($exp(-0.125 * real'(k)) * 4096.0 + 0.5);
   endfunction

   task automatic model(input int g[NE], input int s[NE*NC], output int r[NC], output int c);
      int mx;
      longint w[NE];
      longint tot, rc, acc;
      mx = g[0];
      for (int i = 1; i < NE; i++) if (g[i] > mx) mx = g[i];
      tot = 0;
      for (int i = 0; i < NE; i++) begin
         w[i] = m_exp(mx - g[i]);
         tot += w[i];
      end
      rc = (64'sd1 <<< 24) / tot;
      for (int k = 0; k < NC; k++) begin
         acc = 0;
         for (int i = 0; i < NE; i++) acc += w[i] * s[i*NC+k];
         r[k] = int'((acc * rc) >>> 24);
      end
      c = 0;
      for (int k = 1; k < NC; k++) if (r[k] > r[c]) c = k;
   endtask

   task automatic broadcast(input int g[NE]);
      for (int i = 0; i < NE; i++) gate_score[i*DW +: DW] = DW'(g[i]);
      bcast_valid = 1'b1;
      @(negedge clk);
      bcast_valid = 1'b0;
      gate_score = {NE{16'h3C3C}};
      chk(bcast_ready == 1'b0, "R2 ready low after broadcast", bcast_ready, 0);
   endtask

   task automatic drive_exp(input int x, input int s[NE*NC]);
      for (int k = 0; k < NC; k++) exp_score[(x*NC+k)*DW +: DW] = DW'(s[x*NC+k]);
      exp_valid[x] = 1'b1;
      @(negedge clk);
      exp_valid[x] = 1'b0;
      for (int k = 0; k < NC; k++) exp_score[(x*NC+k)*DW +: DW] = 16'h5A5A;
   endtask

   task automatic collect(input int r[NC], input int c, input string tag);
      int act;
      @(negedge clk);
      chk(mix_done == 1'b0, {tag, " R5 no early done"}, mix_done, 0);
      @(negedge clk);
      chk(mix_done == 1'b1, {tag, " R5 done pulse"}, mix_done, 1);
      for (int k = 0; k < NC; k++) begin
         act = int'($signed(mix_score[k*DW +: DW]));
         chk(act == r[k], {tag, " R7 combined score"}, act, r[k]);
      end
      chk(int'(mix_class) == c, {tag, " R8 class"}, mix_class, c);
      @(negedge clk);
      chk(mix_done == 1'b0, {tag, " R5 single-cycle done"}, mix_done, 0);
      chk(bcast_ready == 1'b1, {tag, " R2 ready restored"}, bcast_ready, 1);
   endtask

   task automatic run(input int g[NE], input int s[NE*NC], input int first, input int gap,
                      input string tag);
      int r[NC];
      int c;
      model(g, s, r, c);
      broadcast(g);
      for (int j = 0; j < NE; j++) begin
         repeat (gap) @(negedge clk);
         drive_exp((first + j) % NE, s);
      end
      collect(r, c, tag);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int ga[NE], gb[NE];
      int sa[NE*NC], sj[NE*NC], st[NE*NC];
      int r[NC];
      int c;
      logic [NC*DW-1:0] keep_s;
      logic [1:0] keep_c;
      bit stray;

      repeat (3) @(negedge clk);
      // R1: reset values
      chk(bcast_ready == 1'b1, "R1 ready in reset", bcast_ready, 1);
      chk(mix_done == 1'b0, "R1 done in reset", mix_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mix_score == '0, "R1 scores zero", mix_score, 0);
      chk(mix_class == '0, "R1 class zero", mix_class, 0);

      // Table walk (R6 saturated weight in vector 2, R7 extremes in vector 4)
      for (int v = 0; v < NV; v++) begin
         run(VG[v], VS[v], v % NE, v % 3, $sformatf("R6 vec%0d", v));
      end

      // R2, R3: request while busy and gate bus changes are ignored
      ga = '{4096, 0, 0};
      gb = '{0, 0, 4096};
      sa = '{300, -300, 600, 0,  100, 900, -100, 50,  -700, 800, 10, 20};
      model(ga, sa, r, c);
      broadcast(ga);
      for (int i = 0; i < NE; i++) gate_score[i*DW +: DW] = DW'(gb[i]);
      bcast_valid = 1'b1;
      @(negedge clk);
      bcast_valid = 1'b0;
      chk(bcast_ready == 1'b0, "R2 busy request refused", bcast_ready, 0);
      drive_exp(2, sa);
      drive_exp(0, sa);
      drive_exp(1, sa);
      collect(r, c, "R3 gate held");

      // R4: repeated strobe from one expert is ignored
      sj = '{-9000, 9000, 9000, 9000,  -9000, 9000, 9000, 9000,  -9000, 9000, 9000, 9000};
      model(ga, sa, r, c);
      broadcast(ga);
      drive_exp(1, sa);
      drive_exp(1, sj);
      drive_exp(0, sa);
      drive_exp(2, sa);
      collect(r, c, "R4 first capture");

      // R9, R10: strobes while idle change nothing
      keep_s = mix_score;
      keep_c = mix_class;
      stray = 1'b0;
      exp_valid = '1;
      exp_score = {NE*NC{16'h7123}};
      gate_score = {NE{16'h1000}};
      repeat (3) begin
         @(negedge clk);
         if (mix_done) stray = 1'b1;
      end
      exp_valid = '0;
      chk(stray == 1'b0, "R10 no done from idle strobes", stray, 0);
      chk(mix_score == keep_s, "R9 scores held", mix_score, keep_s);
      chk(mix_class == keep_c, "R9 class held", mix_class, keep_c);

      // R10: idle strobe from expert 0 does not count toward completion
      drive_exp(0, sj);
      gb = '{-300, 200, 0};
      model(gb, sa, r, c);
      broadcast(gb);
      drive_exp(1, sa);
      drive_exp(2, sa);
      stray = 1'b0;
      repeat (4) begin
         @(negedge clk);
         if (mix_done) stray = 1'b1;
      end
      chk(stray == 1'b0, "R10 waits for expert 0", stray, 0);
      drive_exp(0, sa);
      collect(r, c, "R10 late expert");

      // R8: ties go to the lowest index
      st = '{500, 500, -1, 500,  500, 500, -1, 500,  500, 500, -1, 500};
      run('{0, 0, 0}, st, 0, 0, "R8 tie 0/1/3");
      chk(mix_class == 2'd0, "R8 tie picks class 0", mix_class, 0);
      st = '{-5, 7, 7, 2,  -5, 7, 7, 2,  -5, 7, 7, 2};
      run('{100, -200, 300}, st, 2, 1, "R8 tie 1/2");
      chk(mix_class == 2'd1, "R8 tie picks class 1", mix_class, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule